// File: doc/BRIEF.md
# Two-Channel Programmable Phase Delay

This block shifts the phase of a voltage sample stream against a current sample stream by delaying each by its own programmable amount. Both streams share one clock and one valid strobe, and each valid cycle carries one signed sample per channel. The voltage channel can be delayed by a whole number of sample periods. The current channel can be delayed by a whole number of sample periods plus a fraction of a period, made by linear interpolation between two neighbouring stored samples.

To get a negative shift of voltage against current, give the current channel the longer total delay. Each fine step is 1/512 of a sample period. At a 4 kHz sample rate the usable relative range is roughly ±500 µs.

Top module: `pd_phase_delay`

## Requirements
- R1: During reset out_valid, v_out and i_out are 0 and the sample history is cleared. Delayed taps read after reset therefore return 0 until real samples have filled them.
- R2: out_valid is in_valid delayed by exactly one clock.
- R3: For v_coarse values 0, 1 and 2, v_out shows the voltage sample taken that many valid samples earlier. A value of 0 is the sample presented with the same strobe. v_out updates at the edge that registers the strobe.
- R4: v_coarse = 3 gives the same result as v_coarse = 2, so the voltage delay is at most two samples.
- R5: The current channel's whole-sample offset k is 0 when i_coarse = 0, and 1 when i_coarse is 1, 2 or 3.
- R6: i_out = a + floor(((b − a)·f + 256) / 512). Here a is the current sample k valid samples back, b is the sample k+1 back, and f is i_fine read as unsigned 0..511.
- R7: With i_fine = 0, i_out equals the current sample k valid samples back exactly.
- R8: i_out is saturated to the signed 24-bit range and never lies outside the interval between a and b, including at full-scale opposite-sign neighbours.
- R9: While in_valid is low, the history does not advance, v_out and i_out hold their values, and v_in and i_in are ignored.
- R10: The code inputs are read in the same cycle as the sample they accompany, so a code change applies to that very sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new sample pair is present |
| v_in | input | 24 | Voltage sample, signed two's complement |
| i_in | input | 24 | Current sample, signed two's complement |
| v_coarse | input | 2 | Voltage whole-sample delay code |
| i_coarse | input | 2 | Current whole-sample delay code (0 or one sample) |
| i_fine | input | 9 | Current fractional delay, in 1/512 sample steps |
| out_valid | output | 1 | Delayed sample pair is present |
| v_out | output | 24 | Delayed voltage sample |
| i_out | output | 24 | Delayed, interpolated current sample |

## Verification
The bench builds the block with its default parameters: 24-bit samples, a 9-bit fraction, a voltage limit of two samples and a current coarse limit of one sample. With these values every code value can be reached, including the clamped voltage code 3. Full-scale samples of opposite sign bring the largest interpolation difference, and with it the rounding edge cases, within reach. Because the history is only two deep, a few pushes after a reset show the cleared taps.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned PD_SAMPLE_W = 24;
  localparam int unsigned PD_FRAC_W   = 9;
  localparam int unsigned PD_CODE_W   = 2;

  // limit a delay code to the deepest tap a channel may use
  function automatic int unsigned pd_clamp(input int unsigned code, input int unsigned lim);
    return (code > lim) ? lim : code;
  endfunction
endpackage

// File: rtl/pd_history.sv
module pd_history #(
  parameter int unsigned DW    = 24,
  parameter int unsigned DEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift,
  input  logic [DW-1:0]            din,
  output logic [DEPTH:0][DW-1:0]   taps
);
  logic [DEPTH:0][DW-1:0] store;

  assign store[0] = din;

  genvar g;
  generate
    for (g = 1; g <= DEPTH; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n)      store[g] <= '0;
        else if (shift)  store[g] <= store[g-1];
      end
    end
  endgenerate

  assign taps = store;
endmodule

// File: rtl/pd_interp.sv
module pd_interp #(
  parameter int unsigned DW = 24,
  parameter int unsigned FW = 9
) (
  input  logic signed [DW-1:0] near_s,
  input  logic signed [DW-1:0] far_s,
  input  logic        [FW-1:0] frac,
  output logic signed [DW-1:0] y
);
  localparam int unsigned PW = DW + FW + 2;
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  function automatic logic signed [PW-1:0] lerp_wide(input logic signed [DW-1:0] a,
                                                     input logic signed [DW-1:0] b,
                                                     input logic [FW-1:0] f);
    logic signed [PW-1:0] d, p;
    d = PW'(b) - PW'(a);
    p = d * PW'($signed({1'b0, f}));
    p = p + (PW'(1) <<< (FW - 1));
    return PW'(a) + (p >>> FW);
  endfunction

  function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] v);
    if (v > MAXV) return MAXV[DW-1:0];
    if (v < MINV) return MINV[DW-1:0];
    return v[DW-1:0];
  endfunction

  logic signed [PW-1:0] wide;
  assign wide = lerp_wide(near_s, far_s, frac);
  assign y    = sat(wide);

  // R8: result stays between the two neighbours it blends
  always_comb begin
    a_r8_bounded: assert (((y >= near_s) && (y <= far_s)) || ((y <= near_s) && (y >= far_s)));
  end
endmodule

// File: rtl/pd_phase_delay.sv
module pd_phase_delay
  import pd_pkg::*;
#(
  parameter int unsigned DW    = PD_SAMPLE_W,
  parameter int unsigned FW    = PD_FRAC_W,
  parameter int unsigned CW    = PD_CODE_W,
  parameter int unsigned V_MAX = 2,
  parameter int unsigned I_MAX = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] v_in,
  input  logic [DW-1:0] i_in,
  input  logic [CW-1:0] v_coarse,
  input  logic [CW-1:0] i_coarse,
  input  logic [FW-1:0] i_fine,
  output logic          out_valid,
  output logic [DW-1:0] v_out,
  output logic [DW-1:0] i_out
);
  localparam int unsigned DEPTH = (V_MAX > I_MAX + 1) ? V_MAX : I_MAX + 1;

  logic                   sample_take;
  logic [DEPTH:0][DW-1:0] v_taps, i_taps;
  int unsigned            v_tap_sel, i_tap_sel;
  logic signed [DW-1:0]   v_pick, i_near, i_far, i_blend;

  assign sample_take = in_valid;

  pd_history #(.DW(DW), .DEPTH(DEPTH)) u_vhist (
    .clk(clk), .rst_n(rst_n), .shift(sample_take), .din(v_in), .taps(v_taps)
  );
  pd_history #(.DW(DW), .DEPTH(DEPTH)) u_ihist (
    .clk(clk), .rst_n(rst_n), .shift(sample_take), .din(i_in), .taps(i_taps)
  );

  always_comb begin
    v_tap_sel = pd_clamp(int'(v_coarse), V_MAX);
    i_tap_sel = pd_clamp(int'(i_coarse), I_MAX);
    v_pick    = v_taps[v_tap_sel];
    i_near    = i_taps[i_tap_sel];
    i_far     = i_taps[i_tap_sel + 1];
  end

  pd_interp #(.DW(DW), .FW(FW)) u_interp (
    .near_s(i_near), .far_s(i_far), .frac(i_fine), .y(i_blend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      v_out     <= '0;
      i_out     <= '0;
    end else begin
      out_valid <= sample_take;
      if (sample_take) begin
        v_out <= v_pick;
        i_out <= i_blend;
      end
    end
  end

  // R2: strobe follows input strobe by one clock
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9: no strobe, no change at the outputs
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(v_out) && $stable(i_out)));
  // R3: zero voltage code passes the sample straight through
  a_r3_v_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && v_coarse == '0) |=> (v_out == $past(v_in)));
  // R7: zero fine and zero coarse pass the current sample straight through
  a_r7_i_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && i_coarse == '0 && i_fine == '0) |=> (i_out == $past(i_in)));
endmodule

// File: tb/sim_pd_phase_delay.sv
module sim_pd_phase_delay;
  typedef struct packed {
    logic signed [23:0] v;
    logic signed [23:0] i;
    logic [1:0]         vc;
    logic [1:0]         ic;
    logic [8:0]         f;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{24'sd1000,     24'sd2000,     2'd0, 2'd0, 9'd0},
    '{24'sd3000,    -24'sd4000,     2'd1, 2'd0, 9'd256},
    '{-24'sd5000,    24'sd6000,     2'd2, 2'd1, 9'd0},
    '{24'sd7000,     24'sd100,      2'd3, 2'd1, 9'd1},
    '{24'sd8388607, -24'sd8388608,  2'd0, 2'd2, 9'd511},
    '{-24'sd8388608, 24'sd8388607,  2'd1, 2'd0, 9'd511},
    '{24'sd12345,    24'sd8388607,  2'd2, 2'd0, 9'd255},
    '{24'sd1,        24'sd3,        2'd3, 2'd0, 9'd256},
    '{-24'sd1,      -24'sd2,        2'd1, 2'd3, 9'd256},
    '{24'sd99,       24'sd0,        2'd0, 2'd1, 9'd257},
    '{24'sd500,     -24'sd1,        2'd2, 2'd1, 9'd384},
    '{-24'sd77,      24'sd50,       2'd3, 2'd0, 9'd128}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] v_in = '0, i_in = '0;
  logic [1:0]  v_coarse = '0, i_coarse = '0;
  logic [8:0]  i_fine = '0;
  logic        out_valid;
  logic [23:0] v_out, i_out;

  int n_checks = 0;
  int n_fail = 0;
  logic signed [23:0] mv [0:2];
  logic signed [23:0] mi [0:2];

  always #5 clk = ~clk;

  pd_phase_delay u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .v_in(v_in), .i_in(i_in),
    .v_coarse(v_coarse), .i_coarse(i_coarse), .i_fine(i_fine),
    .out_valid(out_valid), .v_out(v_out), .i_out(i_out)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  function automatic logic signed [23:0] ref_v(input logic [1:0] vc);
    return mv[(vc == 2'd3) ? 2 : int'(vc)];
  endfunction

  // floor-division restatement of the interpolation rule
  function automatic logic signed [23:0] ref_i(input logic [1:0] ic, input logic [8:0] f);
    longint a, b, t, q, r;
    int k;
    k = (ic == 2'd0) ? 0 : 1;
    a = longint'(mi[k]);
    b = longint'(mi[k+1]);
    t = (b - a) * longint'(f) + 256;
    q = (t >= 0) ? t / 512 : -((-t + 511) / 512);
    r = a + q;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return 24'(r);
  endfunction

  task automatic model_shift();
    mv[2] = mv[1]; mv[1] = mv[0];
    mi[2] = mi[1]; mi[1] = mi[0];
  endtask

  task automatic model_clear();
    for (int j = 0; j < 3; j++) begin mv[j] = '0; mi[j] = '0; end
  endtask

  // drive one sample with a gap cycle after it, then check outputs
  task automatic push(input vec_t s, input string rv, input string ri);
    logic signed [23:0] ev, ei;
    @(negedge clk);
    in_valid = 1'b1; v_in = s.v; i_in = s.i;
    v_coarse = s.vc; i_coarse = s.ic; i_fine = s.f;
    mv[0] = s.v; mi[0] = s.i;
    ev = ref_v(s.vc);
    ei = ref_i(s.ic, s.f);
    model_shift();
    @(negedge clk);
    in_valid = 1'b0;
    v_in = 24'h5A5A5A; i_in = 24'hA5A5A5;
    check("R2 out_valid", {23'd0, out_valid}, 24'd1);
    check(rv, v_out, ev);
    check(ri, i_out, ei);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic [23:0] hv, hi;
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 out_valid in reset", {23'd0, out_valid}, 24'd0);
    check("R1 v_out in reset", v_out, 24'd0);
    check("R1 i_out in reset", i_out, 24'd0);
    rst_n = 1'b1;

    // table walk: R3 R4 R5 R6 R7 R8 R10 (codes change per row)
    for (int r = 0; r < NV; r++) begin
      push(TBL[r], "R3/R4/R10 v_out table", "R5/R6/R7/R8 i_out table");
    end

    // R9: idle cycles with junk data leave outputs and history untouched
    hv = v_out; hi = i_out;
    repeat (3) begin
      @(negedge clk);
      v_in = 24'h123456; i_in = 24'h654321;
    end
    check("R9 v_out held", v_out, hv);
    check("R9 i_out held", i_out, hi);
    check("R9 out_valid low", {23'd0, out_valid}, 24'd0);
    push('{24'sd40, 24'sd80, 2'd2, 2'd1, 9'd0}, "R9 v history not advanced", "R9 i history not advanced");

    // R2: back-to-back strobes
    @(negedge clk);
    in_valid = 1'b1; v_in = 24'sd11; i_in = 24'sd22;
    v_coarse = 2'd0; i_coarse = 2'd0; i_fine = 9'd0;
    mv[0] = 24'sd11; mi[0] = 24'sd22; model_shift();
    @(negedge clk);
    v_in = 24'sd33; i_in = 24'sd44; v_coarse = 2'd1; i_coarse = 2'd1;
    check("R2 first b2b valid", {23'd0, out_valid}, 24'd1);
    check("R2 first b2b v", v_out, 24'sd11);
    mv[0] = 24'sd33; mi[0] = 24'sd44;
    hv = ref_v(2'd1); hi = ref_i(2'd1, 9'd0); model_shift();
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 second b2b valid", {23'd0, out_valid}, 24'd1);
    check("R10 second b2b v uses new code", v_out, hv);
    check("R7 second b2b i", i_out, hi);
    @(negedge clk);
    check("R2 valid drops", {23'd0, out_valid}, 24'd0);

    // R8: full-scale opposite neighbours, both directions
    push('{24'sd0, -24'sd8388608, 2'd0, 2'd0, 9'd0}, "R3 setup", "R7 setup");
    push('{24'sd0, 24'sd8388607, 2'd0, 2'd0, 9'd511}, "R3 setup", "R8 near negative full scale");
    push('{24'sd0, -24'sd8388608, 2'd0, 2'd0, 9'd511}, "R3 setup", "R8 near positive full scale");
    check("R8 i_out not below min", (i_out == 24'h800000 || $signed(i_out) > -24'sd8388608) ? 24'd1 : 24'd0, 24'd1);

    // R1: reset mid-run clears the history
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 out_valid after reset", {23'd0, out_valid}, 24'd0);
    check("R1 v_out after reset", v_out, 24'd0);
    rst_n = 1'b1; model_clear();
    push('{24'sd900, 24'sd900, 2'd2, 2'd1, 9'd0}, "R1 v tap cleared", "R1 i tap cleared");
    push('{24'sd901, 24'sd901, 2'd3, 2'd1, 9'd256}, "R1 R4 v tap cleared", "R1 R6 i half step");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule